// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block watches the command stream sent to one DRAM rank with several banks. It tracks which banks hold an open row and how long ago each relevant command happened. Every cycle it reports, for each bank, whether a row activate, read, write or precharge could legally go out, and whether a rank refresh could. A controller can use these flags to pick its next command. If a command is issued while its flag is low, the block raises a one-cycle violation pulse.

All spacings are run-time inputs counted in clocks. The write-to-precharge and write-to-read spacings are derived inside the block as tCL − 1 + BL/2 + tWR and tCL − 1 + BL/2 + tWTR, with the burst length set by a parameter. When the rank has been quiet for a programmable number of clocks and some row is still open, an idle timer requests a precharge of every bank. An auto-precharge mode makes each read or write also close its bank.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset every bank is closed and every spacing has expired. ok_act is all ones, ok_rd, ok_wr and ok_pre are all zeros, ok_ref is 1, and viol and pre_all_req are 0.
- R2: A read or write to a bank is allowed no earlier than t_rcd clocks after that bank's activate.
- R3: A precharge to a bank is allowed no earlier than t_ras clocks after that bank's activate. An activate to a bank is allowed no earlier than t_rp clocks after its precharge and t_ras + t_rp clocks after its previous activate.
- R4: Any two activates in the rank are at least t_rrd clocks apart. Any two precharges in the rank are at least t_ptp clocks apart.
- R5: After a refresh, no activate and no refresh is allowed for t_rfc clocks. A refresh is allowed only when all banks are closed and their activate spacings have expired.
- R6: After a read, a precharge needs t_rtp clocks and a write needs t_rtw clocks, rank-wide.
- R7: After a write, a precharge to the same bank needs t_cl − 1 + BURST_LEN/2 + t_wr clocks. A read anywhere in the rank needs t_cl − 1 + BURST_LEN/2 + t_wtr clocks.
- R8: An activate opens its bank and a precharge closes it. Read, write and precharge are allowed only for an open bank, and activate only for a closed bank.
- R9: A command issued while its flag is low makes viol high in the next cycle only. The command is still tracked as issued.
- R10: With auto_pre high, a read or write closes its bank, and that bank's t_rp spacing starts from that command.
- R11: When a row is open and no command has arrived for idle_limit consecutive cycles, pre_all_req rises. idle_limit = 0 disables the request. Any command or a closed rank drops it.
- R12: cmd_op codes are 1 activate, 2 read, 3 write, 4 precharge and 5 refresh. Any other code is ignored, even with cmd_vld high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | A command is issued this cycle |
| cmd_op | input | 3 | Command code (see R12) |
| cmd_bank | input | BW | Target bank |
| t_cl | input | TW | Read latency |
| t_rcd | input | TW | Activate to read/write |
| t_rp | input | TW | Precharge to activate |
| t_ras | input | TW | Activate to precharge |
| t_rrd | input | TW | Activate to activate, rank |
| t_ptp | input | TW | Precharge to precharge, rank |
| t_rtp | input | TW | Read to precharge |
| t_rtw | input | TW | Read to write |
| t_wr | input | TW | Write recovery |
| t_wtr | input | TW | Write to read recovery |
| t_rfc | input | RFC_W | Refresh to activate |
| idle_limit | input | IDLE_W | Idle clocks before precharge-all request |
| auto_pre | input | 1 | Auto-precharge mode |
| ok_act | output | NUM_BANKS | Activate allowed, per bank |
| ok_rd | output | NUM_BANKS | Read allowed, per bank |
| ok_wr | output | NUM_BANKS | Write allowed, per bank |
| ok_pre | output | NUM_BANKS | Precharge allowed, per bank |
| ok_ref | output | 1 | Refresh allowed |
| viol | output | 1 | Illegal command seen last cycle |
| pre_all_req | output | 1 | Request to precharge all banks |

## Verification
All flags and viol are registered, so they reflect a command one cycle after the edge that captured it. For a spacing of N clocks, the flag is low in the cycle N − 1 after the command and high in cycle N. The idle request rises idle_limit + 1 cycles after the last command. The scoreboard stamps each expected value with the exact cycle number it belongs to, from these rules, and the monitor compares it only in that cycle, between clock edges.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5
  } dcg_op_e;
endpackage

// File: rtl/dcg_down_ctr.sv
module dcg_down_ctr #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  output logic          zero_n
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = ld_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
    else                   cnt_d = cnt_q;
  end

  assign zero_n = (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dcg_bank_track.sv
module dcg_bank_track #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit_act,
  input  logic          hit_rd,
  input  logic          hit_wr,
  input  logic          hit_pre,
  input  logic          auto_pre,
  input  logic [CW-1:0] ld_rcd,
  input  logic [CW-1:0] ld_rp,
  input  logic [CW-1:0] ld_ras,
  input  logic [CW-1:0] ld_rc,
  input  logic [CW-1:0] ld_wrp,
  output logic          open_n,
  output logic          col_ok_n,
  output logic          act_ok_n,
  output logic          pre_ok_n
);
  logic open_q, open_d;
  logic auto_close;
  logic rcd_z, rp_z, ras_z, rc_z, wrp_z;

  assign auto_close = (hit_rd || hit_wr) && auto_pre;

  always_comb begin
    open_d = open_q;
    if (hit_act)         open_d = 1'b1;
    else if (hit_pre)    open_d = 1'b0;
    else if (auto_close) open_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) open_q <= 1'b0;
    else     open_q <= open_d;
  end

  dcg_down_ctr #(.CW(CW)) u_rcd (.clk(clk), .rst(rst), .load(hit_act),
    .ld_val(ld_rcd), .zero_n(rcd_z));
  dcg_down_ctr #(.CW(CW)) u_rp  (.clk(clk), .rst(rst), .load(hit_pre || auto_close),
    .ld_val(ld_rp), .zero_n(rp_z));
  dcg_down_ctr #(.CW(CW)) u_ras (.clk(clk), .rst(rst), .load(hit_act),
    .ld_val(ld_ras), .zero_n(ras_z));
  dcg_down_ctr #(.CW(CW)) u_rc  (.clk(clk), .rst(rst), .load(hit_act),
    .ld_val(ld_rc), .zero_n(rc_z));
  dcg_down_ctr #(.CW(CW)) u_wrp (.clk(clk), .rst(rst), .load(hit_wr),
    .ld_val(ld_wrp), .zero_n(wrp_z));

  assign open_n   = open_d;
  assign col_ok_n = rcd_z;
  assign act_ok_n = rp_z && rc_z;
  assign pre_ok_n = ras_z && wrp_z;
endmodule

// File: rtl/dcg_rank_track.sv
module dcg_rank_track #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          any_act,
  input  logic          any_rd,
  input  logic          any_wr,
  input  logic          any_pre,
  input  logic          any_ref,
  input  logic [CW-1:0] ld_rrd,
  input  logic [CW-1:0] ld_ptp,
  input  logic [CW-1:0] ld_rtp,
  input  logic [CW-1:0] ld_rtw,
  input  logic [CW-1:0] ld_wtr,
  input  logic [CW-1:0] ld_rfc,
  output logic          act_ok_n,
  output logic          pre_ok_n,
  output logic          rd_ok_n,
  output logic          wr_ok_n,
  output logic          ref_ok_n
);
  localparam int NT = 6;
  logic [NT-1:0] ld_en, tz;
  logic [CW-1:0] ld_v [NT];

  assign ld_en = {any_ref, any_wr, any_rd, any_rd, any_pre, any_act};

  always_comb begin
    ld_v[0] = ld_rrd;
    ld_v[1] = ld_ptp;
    ld_v[2] = ld_rtp;
    ld_v[3] = ld_rtw;
    ld_v[4] = ld_wtr;
    ld_v[5] = ld_rfc;
  end

  for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
    dcg_down_ctr #(.CW(CW)) u_tmr (.clk(clk), .rst(rst), .load(ld_en[gi]),
      .ld_val(ld_v[gi]), .zero_n(tz[gi]));
  end

  assign act_ok_n = tz[0] && tz[5];
  assign pre_ok_n = tz[1] && tz[2];
  assign wr_ok_n  = tz[3];
  assign rd_ok_n  = tz[4];
  assign ref_ok_n = tz[5];
endmodule

// File: rtl/dcg_idle_timer.sv
module dcg_idle_timer #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          any_open_n,
  input  logic [IW-1:0] limit,
  output logic          req_q
);
  logic [IW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (busy)        cnt_d = '0;
    else if (&cnt_q) cnt_d = cnt_q;
    else             cnt_d = cnt_q + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req_q <= (limit != '0) && (cnt_d >= limit) && any_open_n;
    end
  end
endmodule

// File: rtl/dram_cmd_guard.sv
module dram_cmd_guard
  import dcg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TW        = 8,
  parameter int RFC_W     = 10,
  parameter int IDLE_W    = 16,
  parameter int BURST_LEN = 8,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_vld,
  input  logic [2:0]           cmd_op,
  input  logic [BW-1:0]        cmd_bank,
  input  logic [TW-1:0]        t_cl,
  input  logic [TW-1:0]        t_rcd,
  input  logic [TW-1:0]        t_rp,
  input  logic [TW-1:0]        t_ras,
  input  logic [TW-1:0]        t_rrd,
  input  logic [TW-1:0]        t_ptp,
  input  logic [TW-1:0]        t_rtp,
  input  logic [TW-1:0]        t_rtw,
  input  logic [TW-1:0]        t_wr,
  input  logic [TW-1:0]        t_wtr,
  input  logic [RFC_W-1:0]     t_rfc,
  input  logic [IDLE_W-1:0]    idle_limit,
  input  logic                 auto_pre,
  output logic [NUM_BANKS-1:0] ok_act,
  output logic [NUM_BANKS-1:0] ok_rd,
  output logic [NUM_BANKS-1:0] ok_wr,
  output logic [NUM_BANKS-1:0] ok_pre,
  output logic                 ok_ref,
  output logic                 viol,
  output logic                 pre_all_req
);
  localparam int CW = ((TW + 3) > RFC_W) ? (TW + 3) : (RFC_W + 1);
  localparam logic [CW-1:0] HALF_BL = CW'(BURST_LEN / 2);

  function automatic logic [CW-1:0] dec_sat(input logic [CW-1:0] v);
    return (v == '0) ? v : v - CW'(1);
  endfunction

  // spacings and counter load values (spacing minus one)
  logic [CW-1:0] sp_wrp, sp_wtr;
  logic [CW-1:0] ld_rcd, ld_rp, ld_ras, ld_rc, ld_wrp;
  logic [CW-1:0] ld_rrd, ld_ptp, ld_rtp, ld_rtw, ld_wtr, ld_rfc;

  always_comb begin
    sp_wrp = dec_sat(CW'(t_cl) + HALF_BL + CW'(t_wr));
    sp_wtr = dec_sat(CW'(t_cl) + HALF_BL + CW'(t_wtr));
    ld_rcd = dec_sat(CW'(t_rcd));
    ld_rp  = dec_sat(CW'(t_rp));
    ld_ras = dec_sat(CW'(t_ras));
    ld_rc  = dec_sat(CW'(t_ras) + CW'(t_rp));
    ld_wrp = dec_sat(sp_wrp);
    ld_rrd = dec_sat(CW'(t_rrd));
    ld_ptp = dec_sat(CW'(t_ptp));
    ld_rtp = dec_sat(CW'(t_rtp));
    ld_rtw = dec_sat(CW'(t_rtw));
    ld_wtr = dec_sat(sp_wtr);
    ld_rfc = dec_sat(CW'(t_rfc));
  end

  // command decode
  logic is_act, is_rd, is_wr, is_pre, is_ref, cmd_real;
  assign is_act   = cmd_vld && (cmd_op == OP_ACT);
  assign is_rd    = cmd_vld && (cmd_op == OP_RD);
  assign is_wr    = cmd_vld && (cmd_op == OP_WR);
  assign is_pre   = cmd_vld && (cmd_op == OP_PRE);
  assign is_ref   = cmd_vld && (cmd_op == OP_REF);
  assign cmd_real = is_act || is_rd || is_wr || is_pre || is_ref;

  logic [NUM_BANKS-1:0] open_n, col_ok, bact_ok, bpre_ok;
  logic r_act_ok, r_pre_ok, r_rd_ok, r_wr_ok, r_ref_ok;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (cmd_bank == BW'(b));

    dcg_bank_track #(.CW(CW)) u_bank (
      .clk(clk), .rst(rst),
      .hit_act(is_act && sel), .hit_rd(is_rd && sel),
      .hit_wr(is_wr && sel),   .hit_pre(is_pre && sel),
      .auto_pre(auto_pre),
      .ld_rcd(ld_rcd), .ld_rp(ld_rp), .ld_ras(ld_ras), .ld_rc(ld_rc), .ld_wrp(ld_wrp),
      .open_n(open_n[b]), .col_ok_n(col_ok[b]),
      .act_ok_n(bact_ok[b]), .pre_ok_n(bpre_ok[b])
    );

    // R2: a fresh activate blocks column commands to its bank
    assert_act_blocks_col_R2: assert property (@(posedge clk) disable iff (rst)
      (is_act && sel && t_rcd > TW'(1)) |=> (!ok_rd[b] && !ok_wr[b]));

    // R3: a fresh activate blocks precharge of its bank
    assert_act_blocks_pre_R3: assert property (@(posedge clk) disable iff (rst)
      (is_act && sel && t_ras > TW'(1)) |=> !ok_pre[b]);

    // R10: auto-precharge closes the bank at the column command
    assert_auto_close_R10: assert property (@(posedge clk) disable iff (rst)
      (auto_pre && (is_rd || is_wr) && sel) |=> (!ok_rd[b] && !ok_wr[b] && !ok_pre[b]));
  end

  dcg_rank_track #(.CW(CW)) u_rank (
    .clk(clk), .rst(rst),
    .any_act(is_act), .any_rd(is_rd), .any_wr(is_wr), .any_pre(is_pre), .any_ref(is_ref),
    .ld_rrd(ld_rrd), .ld_ptp(ld_ptp), .ld_rtp(ld_rtp), .ld_rtw(ld_rtw),
    .ld_wtr(ld_wtr), .ld_rfc(ld_rfc),
    .act_ok_n(r_act_ok), .pre_ok_n(r_pre_ok), .rd_ok_n(r_rd_ok),
    .wr_ok_n(r_wr_ok), .ref_ok_n(r_ref_ok)
  );

  dcg_idle_timer #(.IW(IDLE_W)) u_idle (
    .clk(clk), .rst(rst), .busy(cmd_real), .any_open_n(|open_n),
    .limit(idle_limit), .req_q(pre_all_req)
  );

  // next-state legality flags
  logic [NUM_BANKS-1:0] ok_act_d, ok_rd_d, ok_wr_d, ok_pre_d;
  logic ok_ref_d, illegal;

  always_comb begin
    ok_act_d = ~open_n & bact_ok & {NUM_BANKS{r_act_ok}};
    ok_rd_d  = open_n & col_ok & {NUM_BANKS{r_rd_ok}};
    ok_wr_d  = open_n & col_ok & {NUM_BANKS{r_wr_ok}};
    ok_pre_d = open_n & bpre_ok & {NUM_BANKS{r_pre_ok}};
    ok_ref_d = ~(|open_n) && (&bact_ok) && r_ref_ok;
  end

  always_comb begin
    illegal = 1'b0;
    if (cmd_vld) begin
      case (cmd_op)
        OP_ACT:  illegal = !ok_act[cmd_bank];
        OP_RD:   illegal = !ok_rd[cmd_bank];
        OP_WR:   illegal = !ok_wr[cmd_bank];
        OP_PRE:  illegal = !ok_pre[cmd_bank];
        OP_REF:  illegal = !ok_ref;
        default: illegal = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_act <= '1;
      ok_rd  <= '0;
      ok_wr  <= '0;
      ok_pre <= '0;
      ok_ref <= 1'b1;
      viol   <= 1'b0;
    end else begin
      ok_act <= ok_act_d;
      ok_rd  <= ok_rd_d;
      ok_wr  <= ok_wr_d;
      ok_pre <= ok_pre_d;
      ok_ref <= ok_ref_d;
      viol   <= illegal;
    end
  end

  // R4: activate spacing is rank-wide
  assert_act_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (is_act && t_rrd > TW'(1)) |=> (ok_act == '0));

  // R5: refresh holds off activates and further refreshes
  assert_ref_holdoff_R5: assert property (@(posedge clk) disable iff (rst)
    (is_ref && t_rfc > RFC_W'(1)) |=> (ok_act == '0 && !ok_ref));

  // R6: read-to-write turnaround
  assert_rd_blocks_wr_R6: assert property (@(posedge clk) disable iff (rst)
    (is_rd && t_rtw > TW'(1)) |=> (ok_wr == '0));

  // R7: write-to-read turnaround
  assert_wr_blocks_rd_R7: assert property (@(posedge clk) disable iff (rst)
    (is_wr && sp_wtr > CW'(1)) |=> (ok_rd == '0));

  // R9: a violation always follows an issued command
  assert_viol_has_cmd_R9: assert property (@(posedge clk) disable iff (rst)
    viol |-> $past(cmd_vld));

  // R11: the idle request only rises after a cycle without a command
  assert_idle_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(pre_all_req) |-> $past(!cmd_real));
endmodule

// File: tb/sim_dram_cmd_guard.sv
`timescale 1ns/1ps
module sim_dram_cmd_guard;
  localparam int NB = 4;
  localparam int BW = 2;
  localparam logic [2:0] C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4, C_REF = 3'd5;
  localparam int K_ACT = 0, K_RD = 1, K_WR = 2, K_PRE = 3, K_REF = 4, K_VIOL = 5, K_REQ = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_vld = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [BW-1:0] cmd_bank = '0;
  logic [7:0] t_cl = 8'd5, t_rcd = 8'd3, t_rp = 8'd4, t_ras = 8'd7, t_rrd = 8'd2;
  logic [7:0] t_ptp = 8'd3, t_rtp = 8'd3, t_rtw = 8'd5, t_wr = 8'd4, t_wtr = 8'd3;
  logic [9:0] t_rfc = 10'd20;
  logic [15:0] idle_limit = 16'd10;
  logic auto_pre = 1'b0;
  logic [NB-1:0] ok_act, ok_rd, ok_wr, ok_pre;
  logic ok_ref, viol, pre_all_req;

  dram_cmd_guard #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .t_cl(t_cl), .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras), .t_rrd(t_rrd),
    .t_ptp(t_ptp), .t_rtp(t_rtp), .t_rtw(t_rtw), .t_wr(t_wr), .t_wtr(t_wtr),
    .t_rfc(t_rfc), .idle_limit(idle_limit), .auto_pre(auto_pre),
    .ok_act(ok_act), .ok_rd(ok_rd), .ok_wr(ok_wr), .ok_pre(ok_pre),
    .ok_ref(ok_ref), .viol(viol), .pre_all_req(pre_all_req)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    when;
    int    kind;
    int    bank;
    bit    val;
    string tag;
  } exp_t;
  exp_t sbq[$];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic bit probe(input int kind, input int bank);
    case (kind)
      K_ACT:  return ok_act[bank];
      K_RD:   return ok_rd[bank];
      K_WR:   return ok_wr[bank];
      K_PRE:  return ok_pre[bank];
      K_REF:  return ok_ref;
      K_VIOL: return viol;
      default: return pre_all_req;
    endcase
  endfunction

  // monitor: compare each expected item in its own cycle, between edges
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].when <= cyc) begin
        bit got;
        got = probe(sbq[i].kind, sbq[i].bank);
        n_chk++;
        if (sbq[i].when < cyc || got !== sbq[i].val) begin
          n_bad++;
          $display("FAIL %s: kind %0d bank %0d cycle %0d actual %0b expected %0b",
                   sbq[i].tag, sbq[i].kind, sbq[i].bank, sbq[i].when, got, sbq[i].val);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic expect_at(input int when, input int kind, input int bank,
                           input bit val, input string tag);
    exp_t e;
    e.when = when; e.kind = kind; e.bank = bank; e.val = val; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic issue_at(input int when, input logic [2:0] op, input int bank);
    while (cyc < when) @(negedge clk);
    cmd_vld = 1'b1; cmd_op = op; cmd_bank = bank[BW-1:0];
    @(negedge clk);
    cmd_vld = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic do_reset();
    while (sbq.size() != 0) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual unfinished, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int a, p, r, w, c, d, f, g;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    a = cyc + 1;
    expect_at(a, K_ACT, 0, 1'b1, "R1");
    expect_at(a, K_ACT, 3, 1'b1, "R1");
    expect_at(a, K_RD, 1, 1'b0, "R1");
    expect_at(a, K_WR, 2, 1'b0, "R1");
    expect_at(a, K_PRE, 0, 1'b0, "R1");
    expect_at(a, K_REF, 0, 1'b1, "R1");
    expect_at(a, K_VIOL, 0, 1'b0, "R1");
    expect_at(a + 15, K_REQ, 0, 1'b0, "R11 no open row");

    // R2, R3, R4, R8: activate then precharge on bank 0
    do_reset();
    a = cyc + 1; p = a + 7;
    expect_at(a + 1, K_ACT, 0, 1'b0, "R8 open bank");
    expect_at(a + 1, K_VIOL, 0, 1'b0, "R9 legal");
    expect_at(a + 1, K_ACT, 1, 1'b0, "R4 rrd");
    expect_at(a + 2, K_ACT, 1, 1'b1, "R4 rrd");
    expect_at(a + 2, K_RD, 0, 1'b0, "R2 rcd");
    expect_at(a + 3, K_RD, 0, 1'b1, "R2 rcd");
    expect_at(a + 6, K_PRE, 0, 1'b0, "R3 ras");
    expect_at(a + 7, K_PRE, 0, 1'b1, "R3 ras");
    expect_at(p + 1, K_RD, 0, 1'b0, "R8 closed bank");
    expect_at(p + 3, K_ACT, 0, 1'b0, "R3 rp");
    expect_at(p + 4, K_ACT, 0, 1'b1, "R3 rp");
    issue_at(a, C_ACT, 0);
    issue_at(p, C_PRE, 0);

    // R4: precharge spacing across banks
    do_reset();
    a = cyc + 1; p = a + 7;
    expect_at(p + 2, K_PRE, 1, 1'b0, "R4 ptp");
    expect_at(p + 3, K_PRE, 1, 1'b1, "R4 ptp");
    expect_at(p + 1, K_VIOL, 0, 1'b0, "R4 legal");
    issue_at(a, C_ACT, 0);
    issue_at(a + 2, C_ACT, 1);
    issue_at(p, C_PRE, 0);

    // R6, R7: read and write turnarounds
    do_reset();
    a = cyc + 1; r = a + 8; w = r + 5;
    expect_at(r + 2, K_PRE, 0, 1'b0, "R6 rtp");
    expect_at(r + 3, K_PRE, 0, 1'b1, "R6 rtp");
    expect_at(r + 4, K_WR, 0, 1'b0, "R6 rtw");
    expect_at(r + 5, K_WR, 0, 1'b1, "R6 rtw");
    expect_at(w + 10, K_RD, 0, 1'b0, "R7 wtr");
    expect_at(w + 11, K_RD, 0, 1'b1, "R7 wtr");
    expect_at(w + 11, K_PRE, 0, 1'b0, "R7 wrp");
    expect_at(w + 12, K_PRE, 0, 1'b1, "R7 wrp");
    issue_at(a, C_ACT, 0);
    issue_at(r, C_RD, 0);
    issue_at(w, C_WR, 0);

    // R9: violations
    do_reset();
    c = cyc + 1; d = c + 3;
    expect_at(c + 1, K_VIOL, 0, 1'b1, "R9 read closed");
    expect_at(c + 2, K_VIOL, 0, 1'b0, "R9 pulse");
    expect_at(d + 21, K_VIOL, 0, 1'b1, "R9 act open");
    expect_at(d + 22, K_VIOL, 0, 1'b0, "R9 pulse");
    expect_at(d + 22, K_RD, 2, 1'b0, "R9 still tracked");
    expect_at(d + 23, K_RD, 2, 1'b1, "R9 still tracked");
    issue_at(c, C_RD, 2);
    issue_at(d, C_ACT, 2);
    issue_at(d + 20, C_ACT, 2);

    // R5: refresh
    do_reset();
    f = cyc + 1;
    expect_at(f + 1, K_REF, 0, 1'b0, "R5 rfc");
    expect_at(f + 19, K_ACT, 0, 1'b0, "R5 rfc");
    expect_at(f + 20, K_ACT, 0, 1'b1, "R5 rfc");
    expect_at(f + 20, K_REF, 0, 1'b1, "R5 rfc");
    expect_at(f + 22, K_REF, 0, 1'b0, "R5 open bank");
    issue_at(f, C_REF, 0);
    issue_at(f + 21, C_ACT, 3);

    // R10: auto-precharge
    do_reset();
    auto_pre = 1'b1;
    a = cyc + 1; r = a + 8;
    expect_at(r + 1, K_RD, 0, 1'b0, "R10 closed");
    expect_at(r + 1, K_PRE, 0, 1'b0, "R10 closed");
    expect_at(r + 3, K_ACT, 0, 1'b0, "R10 rp");
    expect_at(r + 4, K_ACT, 0, 1'b1, "R10 rp");
    issue_at(a, C_ACT, 0);
    issue_at(r, C_RD, 0);
    while (sbq.size() != 0) @(negedge clk);
    auto_pre = 1'b0;

    // R11: idle request
    do_reset();
    a = cyc + 1; p = a + 12;
    expect_at(a + 10, K_REQ, 0, 1'b0, "R11 idle");
    expect_at(a + 11, K_REQ, 0, 1'b1, "R11 idle");
    expect_at(p + 1, K_REQ, 0, 1'b0, "R11 drop");
    issue_at(a, C_ACT, 0);
    issue_at(p, C_PRE, 0);

    // R12: unknown code ignored
    do_reset();
    g = cyc + 1;
    expect_at(g + 1, K_ACT, 0, 1'b1, "R12 ignored");
    expect_at(g + 1, K_RD, 0, 1'b0, "R12 ignored");
    expect_at(g + 1, K_VIOL, 0, 1'b0, "R12 ignored");
    issue_at(g, 3'd6, 0);

    while (sbq.size() != 0) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule